// File: doc/BRIEF.md
# Reed-Solomon Symbol Error Applier

This block sits after a Reed-Solomon decoder in a flash page controller. The decoder hands over one batch per page. A batch holds a count and up to four (symbol position, 12-bit error pattern) pairs. The block turns each pair into byte edits on a page buffer RAM. Each edit is a read-modify-write: the block reads the byte, XORs it with a mask and writes it back.

The page buffer is addressed linearly. Data bytes sit at addresses 0 to 2047. Spare byte k sits at address 2048+k. Codeword symbols are 12 bits wide, and every two symbols occupy three bytes. Symbol 0 is short and carries only 8 bits.

The whole batch is checked before any memory access. If any used pair cannot be corrected, the buffer is left untouched and a page-failure counter advances. Otherwise every edit is applied. A one-cycle done pulse then reports the outcome and the number of symbols that were fixed.

Top module: `rs_err_apply`

## Requirements
- R1: A used entry whose position exceeds 1374 makes the batch uncorrectable. `done_ok` is then 0 and no buffer write occurs.
- R2: Position 0 with a nonzero pattern bit 11:8 is uncorrectable. Otherwise, position 0 XORs pattern bits 7:0 into address 0 and touches nothing else.
- R3: For an odd position p with 3p/2 below 2047, address 3p/2 is XORed with pattern bits 11:4. Address 3p/2+1 is XORed with pattern bits 3:0 placed in byte bits 7:4.
- R4: For an even position p with 2 ≤ p < 1365, address 3p/2−1 is XORed with pattern bits 11:8 placed in byte bits 3:0. Address 3p/2 is XORed with pattern bits 7:0.
- R5: Position 1365 edits data byte 2047 (address 2047) with pattern bits 11:4. It edits spare byte 0 (address 2048) with pattern bits 3:0 placed in byte bits 7:4.
- R6: Positions 1366 to 1374 follow the odd/even rules, but land in the spare area. The spare index is the data formula minus 2048, at address 2048 plus that index. Position 1374 therefore edits spare bytes 12 and 13.
- R7: A count above 4 makes the batch uncorrectable.
- R8: If any used entry is uncorrectable, none of the batch's edits is written, including those of valid entries.
- R9: On success, `done_ok` is 1 and `fixed_cnt` equals the count. On failure, `fixed_cnt` is 0. A count of 0 completes with `done_ok` 1, `fixed_cnt` 0 and no buffer access.
- R10: Entries at index count or above are neither validated nor applied.
- R11: Each byte takes two cycles: a read, then a write to the same address using the data returned one cycle later. `done` is high for exactly one cycle, the cycle after the last write. For a batch of n byte edits, `done` appears 2n+1 rising edges after acceptance, counting the accepting edge. `in_ready` is high only while the block is idle.
- R12: `fail_cnt` increases by one for each uncorrectable batch and is unchanged by successful ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Batch offered |
| in_ready | output | 1 | Block idle, batch accepted on this edge if valid |
| in_count | input | 3 | Number of used entries (0 to 7, above 4 is uncorrectable) |
| in_pos | input | 44 | Four 11-bit symbol positions, entry i at bits 11i+10:11i |
| in_pat | input | 48 | Four 12-bit error patterns, entry i at bits 12i+11:12i |
| mem_addr | output | 12 | Buffer byte address |
| mem_rd_en | output | 1 | Buffer read strobe, data returned next cycle |
| mem_wr_en | output | 1 | Buffer write strobe |
| mem_wdata | output | 8 | Corrected byte to write |
| mem_rdata | input | 8 | Read data, one cycle after `mem_rd_en` |
| done | output | 1 | One-cycle completion pulse |
| done_ok | output | 1 | Batch was applied (valid with `done`) |
| fixed_cnt | output | 3 | Symbols corrected (valid with `done`) |
| fail_cnt | output | 16 | Running count of uncorrectable batches |

## Verification
The hardest case to reach is a batch that mixes valid entries with one bad entry in a late slot, where the whole batch must still leave memory untouched. A related case is a batch whose unused slots hold out-of-range positions that must be ignored. The random generator mixes out-of-range positions, position 0 with polluted upper bits, and counts above four. This makes partial-validity batches frequent. Directed batches cover the boundary symbol 1365, the last spare symbol, and a third-slot failure behind two good entries.

// File: rtl/rs_fix_pkg.sv
package rs_fix_pkg;
    localparam int SYM_W  = 12;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD,
        ST_WR,
        ST_FIN
    } fix_state_e;
endpackage

// File: rtl/sym_locate.sv
module sym_locate
    import rs_fix_pkg::*;
#(
    parameter int POS_W  = 11,
    parameter int ADDR_W = 12
) (
    input  logic [POS_W-1:0]  pos,
    input  logic [SYM_W-1:0]  pat,
    output logic              two_bytes,
    output logic [ADDR_W-1:0] addr0,
    output logic [BYTE_W-1:0] mask0,
    output logic [ADDR_W-1:0] addr1,
    output logic [BYTE_W-1:0] mask1
);
    logic [ADDR_W:0]   tri3;
    logic [ADDR_W-1:0] base;

    assign tri3 = (ADDR_W+1)'(pos) * (ADDR_W+1)'(3);
    assign base = tri3[ADDR_W:1];

    always_comb begin
        two_bytes = 1'b1;
        addr1     = base;
        if (pos == '0) begin
            two_bytes = 1'b0;
            addr0     = '0;
            mask0     = pat[7:0];
            mask1     = '0;
        end else if (pos[0]) begin
            addr0 = base;
            mask0 = pat[11:4];
            addr1 = base + ADDR_W'(1);
            mask1 = {pat[3:0], 4'h0};
        end else begin
            addr0 = base - ADDR_W'(1);
            mask0 = {4'h0, pat[11:8]};
            mask1 = pat[7:0];
        end
    end
endmodule

// File: rtl/batch_judge.sv
module batch_judge #(
    parameter int MAX_ERR  = 4,
    parameter int POS_W    = 11,
    parameter int CNT_W    = 3,
    parameter int LAST_POS = 1374
) (
    input  logic [CNT_W-1:0]         count,
    input  logic [MAX_ERR*POS_W-1:0] pos_flat,
    input  logic [MAX_ERR*4-1:0]     hi_nib_flat,
    output logic                     ok
);
    logic [MAX_ERR-1:0] bad;

    for (genvar i = 0; i < MAX_ERR; i++) begin : g_ent
        logic [POS_W-1:0] p;
        logic             used;
        assign p      = pos_flat[i*POS_W +: POS_W];
        assign used   = CNT_W'(i) < count;
        assign bad[i] = used && ((p > POS_W'(LAST_POS)) ||
                                 (p == '0 && hi_nib_flat[i*4 +: 4] != 4'h0));
    end

    assign ok = (count <= CNT_W'(MAX_ERR)) && (bad == '0);
endmodule

// File: rtl/rs_err_apply.sv
module rs_err_apply
    import rs_fix_pkg::*;
#(
    parameter int MAX_ERR  = 4,
    parameter int POS_W    = 11,
    parameter int ADDR_W   = 12,
    parameter int CNT_W    = 3,
    parameter int FCNT_W   = 16,
    parameter int LAST_POS = 1374
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [CNT_W-1:0]         in_count,
    input  logic [MAX_ERR*POS_W-1:0] in_pos,
    input  logic [MAX_ERR*SYM_W-1:0] in_pat,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic                     mem_rd_en,
    output logic                     mem_wr_en,
    output logic [BYTE_W-1:0]        mem_wdata,
    input  logic [BYTE_W-1:0]        mem_rdata,
    output logic                     done,
    output logic                     done_ok,
    output logic [CNT_W-1:0]         fixed_cnt,
    output logic [FCNT_W-1:0]        fail_cnt
);
    localparam int IDX_W    = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1;
    localparam int ADDR_MAX = (3 * LAST_POS) / 2;

    typedef struct packed {
        fix_state_e                          st;
        logic [MAX_ERR-1:0][POS_W-1:0]       pos;
        logic [MAX_ERR-1:0][SYM_W-1:0]       pat;
        logic [CNT_W-1:0]                    cnt;
        logic [IDX_W-1:0]                    idx;
        logic                                hi;
        logic                                ok;
        logic [FCNT_W-1:0]                   fails;
    } fix_reg_t;

    fix_reg_t r_d, r_q;

    logic [MAX_ERR*4-1:0] hi_nib;
    logic                 judge_ok;
    logic                 two_bytes;
    logic [ADDR_W-1:0]    a0, a1;
    logic [BYTE_W-1:0]    m0, m1;
    logic                 last_ent;

    for (genvar i = 0; i < MAX_ERR; i++) begin : g_nib
        assign hi_nib[i*4 +: 4] = in_pat[i*SYM_W + 8 +: 4];
    end

    batch_judge #(
        .MAX_ERR (MAX_ERR),
        .POS_W   (POS_W),
        .CNT_W   (CNT_W),
        .LAST_POS(LAST_POS)
    ) u_judge (
        .count      (in_count),
        .pos_flat   (in_pos),
        .hi_nib_flat(hi_nib),
        .ok         (judge_ok)
    );

    sym_locate #(
        .POS_W (POS_W),
        .ADDR_W(ADDR_W)
    ) u_loc (
        .pos      (r_q.pos[r_q.idx]),
        .pat      (r_q.pat[r_q.idx]),
        .two_bytes(two_bytes),
        .addr0    (a0),
        .mask0    (m0),
        .addr1    (a1),
        .mask1    (m1)
    );

    assign last_ent = (CNT_W'(r_q.idx) + CNT_W'(1)) == r_q.cnt;

    always_comb begin
        r_d       = r_q;
        in_ready  = (r_q.st == ST_IDLE);
        mem_addr  = r_q.hi ? a1 : a0;
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        mem_wdata = '0;
        done      = 1'b0;
        done_ok   = 1'b0;
        fixed_cnt = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    r_d.pos = in_pos;
                    r_d.pat = in_pat;
                    r_d.cnt = in_count;
                    r_d.ok  = judge_ok;
                    r_d.idx = '0;
                    r_d.hi  = 1'b0;
                    if (!judge_ok) begin
                        r_d.fails = r_q.fails + FCNT_W'(1);
                        r_d.st    = ST_FIN;
                    end else if (in_count == '0) begin
                        r_d.st = ST_FIN;
                    end else begin
                        r_d.st = ST_RD;
                    end
                end
            end
            ST_RD: begin
                mem_rd_en = 1'b1;
                r_d.st    = ST_WR;
            end
            ST_WR: begin
                mem_wr_en = 1'b1;
                mem_wdata = mem_rdata ^ (r_q.hi ? m1 : m0);
                if (!r_q.hi && two_bytes) begin
                    r_d.hi = 1'b1;
                    r_d.st = ST_RD;
                end else if (last_ent) begin
                    r_d.st = ST_FIN;
                end else begin
                    r_d.idx = r_q.idx + IDX_W'(1);
                    r_d.hi  = 1'b0;
                    r_d.st  = ST_RD;
                end
            end
            ST_FIN: begin
                done      = 1'b1;
                done_ok   = r_q.ok;
                fixed_cnt = r_q.ok ? r_q.cnt : '0;
                r_d.st    = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign fail_cnt = r_q.fails;

    assert_rd_then_wr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> (mem_wr_en && $stable(mem_addr)));
    assert_wr_after_rd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(mem_rd_en));
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!mem_rd_en && !mem_wr_en));
    assert_no_write_on_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !judge_ok) |=> (!mem_rd_en && !mem_wr_en && done && !done_ok));
    assert_fail_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !judge_ok) |=> (fail_cnt == $past(fail_cnt) + FCNT_W'(1)));
    assert_fail_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> $stable(fail_cnt));
    assert_fixed_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fixed_cnt <= CNT_W'(MAX_ERR)));
    assert_addr_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_addr <= ADDR_W'(ADDR_MAX)));
endmodule

// File: tb/sim_rs_err_apply.sv
module sim_rs_err_apply;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_count = '0;
    logic [43:0] in_pos = '0;
    logic [47:0] in_pat = '0;
    logic [11:0] mem_addr;
    logic        mem_rd_en, mem_wr_en;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        done, done_ok;
    logic [2:0]  fixed_cnt;
    logic [15:0] fail_cnt;

    int checks = 0;
    int fails  = 0;
    int writes_seen = 0;
    int exp_fail_cnt = 0;

    logic [7:0] ram [4096];
    logic [7:0] exp_mem [4096];

    always #10 clk = ~clk;

    rs_err_apply u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_count(in_count), .in_pos(in_pos), .in_pat(in_pat),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done),
        .done_ok(done_ok), .fixed_cnt(fixed_cnt), .fail_cnt(fail_cnt)
    );

    always @(posedge clk) begin
        if (mem_wr_en) begin
            ram[mem_addr] <= mem_wdata;
            writes_seen   <= writes_seen + 1;
        end
        if (mem_rd_en) mem_rdata <= ram[mem_addr];
    end

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit entry_bad(input int p, input int pt);
        if (p > 1374) return 1'b1;
        if (p == 0 && (pt >> 8) != 0) return 1'b1;
        return 1'b0;
    endfunction

    task automatic exp_edit(input int p, input int pt);
        int t;
        int s;
        t = (3 * p) / 2;
        if (p == 0) begin
            exp_mem[0] ^= pt[7:0];
        end else if (p == 1365) begin
            exp_mem[2047] ^= pt[11:4];
            exp_mem[2048] ^= {pt[3:0], 4'h0};
        end else if (p < 1365) begin
            if (p % 2 == 1) begin
                exp_mem[t]   ^= pt[11:4];
                exp_mem[t+1] ^= {pt[3:0], 4'h0};
            end else begin
                exp_mem[t-1] ^= {4'h0, pt[11:8]};
                exp_mem[t]   ^= pt[7:0];
            end
        end else begin
            if (p % 2 == 1) begin
                s = t - 2048;
                exp_mem[2048+s]   ^= pt[11:4];
                exp_mem[2048+s+1] ^= {pt[3:0], 4'h0};
            end else begin
                s = t - 2049;
                exp_mem[2048+s]   ^= {4'h0, pt[11:8]};
                exp_mem[2048+s+1] ^= pt[7:0];
            end
        end
    endtask

    task automatic run_batch(input int cnt, input logic [43:0] pv, input logic [47:0] tv,
                             input string req);
        bit ok;
        int nb;
        int lat;
        int w0;
        int bad_addr;
        ok = (cnt <= 4);
        nb = 0;
        for (int i = 0; i < 4; i++) begin
            if (i < cnt && entry_bad(int'(pv[i*11 +: 11]), int'(tv[i*12 +: 12]))) ok = 1'b0;
        end
        if (ok) begin
            for (int i = 0; i < cnt; i++) begin
                exp_edit(int'(pv[i*11 +: 11]), int'(tv[i*12 +: 12]));
                nb += (pv[i*11 +: 11] == 11'd0) ? 1 : 2;
            end
        end else begin
            exp_fail_cnt++;
        end
        @(negedge clk);
        chk(in_ready == 1'b1, {req, " R11 ready when idle"}, in_ready, 1);
        in_valid = 1'b1;
        in_count = 3'(cnt);
        in_pos   = pv;
        in_pat   = tv;
        w0 = writes_seen;
        @(posedge clk);
        lat = 0;
        do begin
            @(negedge clk);
            in_valid = 1'b0;
            lat++;
        end while (!done && lat < 40);
        chk(lat == 2*nb + 1, {req, " R11 done latency"}, lat, 2*nb + 1);
        chk(done_ok == ok, {req, " R9 done_ok"}, done_ok, ok);
        chk(int'(fixed_cnt) == (ok ? cnt : 0), {req, " R9 fixed_cnt"}, fixed_cnt, ok ? cnt : 0);
        chk(int'(fail_cnt) == exp_fail_cnt, {req, " R12 fail_cnt"}, fail_cnt, exp_fail_cnt);
        chk(writes_seen - w0 == nb, {req, " R8 write count"}, writes_seen - w0, nb);
        bad_addr = -1;
        for (int a = 0; a < 2112; a++) begin
            if (bad_addr < 0 && ram[a] !== exp_mem[a]) bad_addr = a;
        end
        if (bad_addr < 0) chk(1'b1, {req, " buffer"}, 0, 0);
        else chk(1'b0, {req, " buffer byte (addr ", $sformatf("%0d", bad_addr), ")"},
                 ram[bad_addr], exp_mem[bad_addr]);
        @(negedge clk);
        chk(done == 1'b0, {req, " R11 done single cycle"}, done, 0);
    endtask

    function automatic logic [43:0] pk_pos(input int a, input int b, input int c, input int d);
        return {11'(d), 11'(c), 11'(b), 11'(a)};
    endfunction

    function automatic logic [47:0] pk_pat(input int a, input int b, input int c, input int d);
        return {12'(d), 12'(c), 12'(b), 12'(a)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int cnt;
        int r;
        int p;
        int t;
        logic [43:0] pv;
        logic [47:0] tv;
        void'($urandom(32'd2718));
        for (int a = 0; a < 4096; a++) begin
            ram[a]     = 8'($urandom);
            exp_mem[a] = ram[a];
        end
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b0 || in_ready == 1'b1, "reset ready defined", in_ready, 1);
        chk(done == 1'b0, "R11 reset done low", done, 0);
        chk(fail_cnt == 16'd0, "R12 reset fail_cnt", fail_cnt, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R11 idle after reset", in_ready, 1);

        run_batch(1, pk_pos(0, 0, 0, 0), pk_pat(12'h0A5, 0, 0, 0), "R2 pos0 ok");
        run_batch(1, pk_pos(0, 0, 0, 0), pk_pat(12'h1A5, 0, 0, 0), "R2 pos0 bad");
        run_batch(1, pk_pos(7, 0, 0, 0), pk_pat(12'h9E3, 0, 0, 0), "R3 odd");
        run_batch(1, pk_pos(2, 0, 0, 0), pk_pat(12'h5C7, 0, 0, 0), "R4 even");
        run_batch(1, pk_pos(1365, 0, 0, 0), pk_pat(12'hABC, 0, 0, 0), "R5 straddle");
        run_batch(1, pk_pos(1374, 0, 0, 0), pk_pat(12'h123, 0, 0, 0), "R6 last spare");
        run_batch(2, pk_pos(1367, 1366, 0, 0), pk_pat(12'hF0F, 12'h3D2, 0, 0), "R6 spare pair");
        run_batch(1, pk_pos(1375, 0, 0, 0), pk_pat(12'h001, 0, 0, 0), "R1 over limit");
        run_batch(5, pk_pos(3, 4, 5, 6), pk_pat(1, 2, 3, 4), "R7 count five");
        run_batch(3, pk_pos(10, 11, 1500, 0), pk_pat(12'hFFF, 12'hFFF, 12'h001, 0), "R8 late bad");
        run_batch(2, pk_pos(20, 21, 2000, 1400), pk_pat(12'h111, 12'h222, 12'h333, 12'h444), "R10 unused");
        run_batch(0, pk_pos(2000, 2000, 2000, 2000), pk_pat(0, 0, 0, 0), "R9 empty");
        run_batch(4, pk_pos(30, 30, 31, 0), pk_pat(12'h0F0, 12'h0F0, 12'hA5A, 12'h077), "R9 full");

        for (int n = 0; n < 400; n++) begin
            cnt = ($urandom % 10 == 0) ? 5 + int'($urandom % 3) : int'($urandom % 5);
            for (int i = 0; i < 4; i++) begin
                r = int'($urandom % 100);
                if (r < 4) p = 1375 + int'($urandom % 600);
                else if (r < 12) p = 0;
                else if (r < 22) p = 1360 + int'($urandom % 15);
                else p = int'($urandom % 1375);
                t = int'($urandom % 4096);
                if (p == 0 && ($urandom % 2) == 0) t = t & 8'hFF;
                pv[i*11 +: 11] = 11'(p);
                tv[i*12 +: 12] = 12'(t);
            end
            run_batch(cnt, pv, tv, "R1-mix random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule